// File: doc/BRIEF.md
# Sequential-Access Filter Register Bank

This block stores eight 32-bit filter words for a wake-up pattern matcher. Software sees only one register address for the whole bank. An internal entry pointer picks which word a bus access reaches. The pointer steps forward after every read or write at that address, so software can walk the whole bank by accessing the same address again and again. After the eighth access the pointer wraps back to entry 0.

Reads and writes use the same pointer. A mixed series of accesses therefore moves through one shared sequence. A separate clear input sends the pointer back to entry 0, for example when a power-management control register is written. The matching logic reads all eight words at once from a flat parallel output. The block sits on a simple register bus made of address, write strobe, read strobe, write data and registered read data.

Top module: `seq_filter_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the pointer is 0, all eight entries read as zero on `filt_bank`, and `bus_rdata` is zero.
- R2: A write strobe with `bus_addr` equal to `BANK_ADDR` stores `bus_wdata` into the entry selected by the pointer. The new value appears on `filt_bank` after that clock edge.
- R3: A read strobe with `bus_addr` equal to `BANK_ADDR` loads the selected entry into `bus_rdata` on that clock edge. `bus_rdata` then holds that value until the next bank read.
- R4: Each bank access moves the pointer up by exactly one, and from 7 it wraps to 0. Eight writes after reset fill entries 0 through 7 in order, and a ninth write lands in entry 0 again.
- R5: Reads and writes move the same pointer. In a mixed series, each access uses the entry that directly follows the one used by the previous access.
- R6: If read and write strobes arrive at the bank address in the same cycle, the entry takes the write data, `bus_rdata` gets the contents the entry held before the write, and the pointer moves forward only once.
- R7: `ptr_clr` high at a clock edge sets the pointer to 0 and takes priority over the step forward. A bank access in that same cycle still uses the pointer value it had before the clear.
- R8: An access at any address other than `BANK_ADDR` leaves the pointer, every entry and `bus_rdata` unchanged.
- R9: Entry k appears on `filt_bank[32*k+31 : 32*k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_clr | input | 1 | Sends the entry pointer back to 0 |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| filt_bank | output | 256 | All eight entries side by side, entry 0 in the low bits |

## Verification
The pointer cannot be seen directly. A wrong pointer value therefore shows up in two ways: as a write that changes the wrong slice of `filt_bank` one cycle after the strobe, or as a read that returns a neighbouring entry's word in `bus_rdata` one cycle later. Because of this, the bench compares `bus_rdata` and all eight slices of `filt_bank` with its behavioural model after every clock. A pointer that slips, fails to wrap, or moves on a foreign address is caught at the first bank access that follows. A stuck or wrongly loaded entry is caught in the same cycle it differs from the model.

// File: rtl/fb_pkg.sv
// Shared constants and types for the sequential-access filter bank.
// Assumes all modules take their default sizes from here.
package fb_pkg;
    localparam int unsigned FB_WORD_W = 32;
    localparam int unsigned FB_DEPTH  = 8;
    localparam int unsigned FB_ADDR_W = 8;

    // Decoded bus strobes for one cycle at the bank address.
    typedef struct packed {
        logic wr;
        logic rd;
    } fb_access_t;
endpackage

// File: rtl/fb_seq_ptr.sv
// Entry pointer for the bank: moves forward one step per access and wraps
// at DEPTH-1. A clear input forces it to 0 and wins over a step.
// Assumes DEPTH >= 2 and a synchronous active-low reset.
module fb_seq_ptr #(
    parameter int unsigned DEPTH = fb_pkg::FB_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_next;

    // Next value on a step: wrap after the last entry.
    always_comb begin
        ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // Pointer register with clear and step.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (clr)   ptr <= '0;
        else if (step)  ptr <= ptr_next;
    end

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0)); // R7
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && ptr == LAST) |=> (ptr == '0)); // R4
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1)); // R4
    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(ptr)); // R8
endmodule

// File: rtl/fb_entry_store.sv
// Storage for DEPTH words. Only the entry named by wr_idx is written, when
// wr_en is high. All entries are shown together on a flat output.
// Assumes wr_idx is always below DEPTH.
module fb_entry_store #(
    parameter int unsigned WORD_W = fb_pkg::FB_WORD_W,
    parameter int unsigned DEPTH  = fb_pkg::FB_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PTR_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    output logic [DEPTH*WORD_W-1:0] bank_flat
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        logic [WORD_W-1:0] word_q;
        logic              sel;

        // Select line for this entry.
        always_comb begin
            sel = wr_en && (wr_idx == PTR_W'(k));
        end

        // Word register: clears on reset, loads when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)   word_q <= '0;
            else if (sel) word_q <= wr_data;
        end

        assign bank_flat[k*WORD_W +: WORD_W] = word_q;

        AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == PTR_W'(k)) |=>
                (bank_flat[k*WORD_W +: WORD_W] == $past(wr_data))); // R2
        AST_ENTRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == PTR_W'(k)) |=>
                $stable(bank_flat[k*WORD_W +: WORD_W])); // R8
    end
endmodule

// File: rtl/fb_read_port.sv
// Registered read path: on rd_en it captures the entry named by rd_idx and
// holds it until the next read. It samples before any write in the same
// cycle takes effect, so a combined access returns the old contents.
module fb_read_port #(
    parameter int unsigned WORD_W = fb_pkg::FB_WORD_W,
    parameter int unsigned DEPTH  = fb_pkg::FB_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [PTR_W-1:0]        rd_idx,
    input  logic [DEPTH*WORD_W-1:0] bank_flat,
    output logic [WORD_W-1:0]       rdata
);
    logic [WORD_W-1:0] sel_word;

    // Pick the addressed entry out of the flat bank.
    always_comb begin
        sel_word = bank_flat[rd_idx*WORD_W +: WORD_W];
    end

    // Read data register, loaded only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel_word;
    end

    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata == $past(bank_flat[rd_idx*WORD_W +: WORD_W]))); // R3
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R8
endmodule

// File: rtl/seq_filter_bank.sv
// Top level: decodes the single bank address and routes strobes to the
// shared pointer, the entry store and the read port. Every word is exposed
// in parallel for the pattern matcher.
// Assumes single-cycle strobes and a synchronous active-low reset.
module seq_filter_bank #(
    parameter int unsigned WORD_W    = fb_pkg::FB_WORD_W,
    parameter int unsigned DEPTH     = fb_pkg::FB_DEPTH,
    parameter int unsigned ADDR_W    = fb_pkg::FB_ADDR_W,
    parameter logic [ADDR_W-1:0] BANK_ADDR = ADDR_W'(8'h28)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ptr_clr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic [DEPTH*WORD_W-1:0] filt_bank
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fb_pkg::fb_access_t acc;
    logic               hit;
    logic               step;
    logic [PTR_W-1:0]   ptr;

    // Address decode and strobe gating.
    always_comb begin
        hit    = (bus_addr == BANK_ADDR);
        acc.wr = hit && bus_wr;
        acc.rd = hit && bus_rd;
        step   = acc.wr || acc.rd;
    end

    fb_seq_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_clr),
        .step  (step),
        .ptr   (ptr)
    );

    fb_entry_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc.wr),
        .wr_idx    (ptr),
        .wr_data   (bus_wdata),
        .bank_flat (filt_bank)
    );

    fb_read_port #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (acc.rd),
        .rd_idx    (ptr),
        .bank_flat (filt_bank),
        .rdata     (bus_rdata)
    );

    AST_FOREIGN_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !ptr_clr) |=> ($stable(filt_bank) && $stable(bus_rdata))); // R8
    AST_COMBINED_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && bus_rd && !ptr_clr && ptr != PTR_W'(DEPTH-1)) |=>
            (ptr == $past(ptr) + 1'b1)); // R6
endmodule

// File: tb/seq_filter_bank_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference (integer array and pointer) compared with
// rdata and every filt_bank slice after each clock.
module seq_filter_bank_bench;
    localparam int W = 32;
    localparam int D = 8;
    localparam logic [7:0] BA = 8'h28;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ptr_clr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [W-1:0]   bus_wdata = '0;
    logic [W-1:0]   bus_rdata;
    logic [D*W-1:0] filt_bank;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] m_bank [D];
    int           m_ptr;
    logic [W-1:0] m_rdata;

    seq_filter_bank u_seq_filter_bank (
        .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .filt_bank(filt_bank)
    );

    always #2.5 clk = ~clk;

    task automatic compare(input string tag);
        total++;
        if (bus_rdata !== m_rdata) begin
            bad++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, m_rdata);
        end
        for (int k = 0; k < D; k++) begin
            total++;
            if (filt_bank[k*W +: W] !== m_bank[k]) begin
                bad++;
                $display("FAIL %s (R9 slice %0d) actual=%h expected=%h",
                         tag, k, filt_bank[k*W +: W], m_bank[k]);
            end
        end
    endtask

    // One bus cycle: drive at negedge, update model at the edge, check after.
    task automatic cyc(input logic [7:0] a, input logic w, input logic r,
                       input logic [W-1:0] d, input logic c, input string tag);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; ptr_clr = c;
        @(posedge clk);
        if (a == BA) begin
            if (r) m_rdata = m_bank[m_ptr];
            if (w) m_bank[m_ptr] = d;
        end
        if (c) m_ptr = 0;
        else if (a == BA && (w || r)) m_ptr = (m_ptr + 1) % D;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; ptr_clr = 1'b0;
        compare(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < D; k++) m_bank[k] = '0;
        m_ptr = 0; m_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        // R2 R4: eight writes fill the bank in order
        for (int i = 0; i < D; i++)
            cyc(BA, 1'b1, 1'b0, 32'hA000_0000 + 32'(i * 17), 1'b0, "R2 R4 fill");
        // R3 R4: eight reads return the words in order
        for (int i = 0; i < D; i++)
            cyc(BA, 1'b0, 1'b1, '0, 1'b0, "R3 R4 read");
        // R4: ninth write after wrap lands in entry 0
        cyc(BA, 1'b1, 1'b0, 32'h1234_5678, 1'b0, "R4 wrap");
        // R5: mixed reads and writes share one sequence
        cyc(BA, 1'b0, 1'b1, '0, 1'b0, "R5 mix");
        cyc(BA, 1'b1, 1'b0, 32'hBEEF_0002, 1'b0, "R5 mix");
        cyc(BA, 1'b0, 1'b1, '0, 1'b0, "R5 mix");
        // R6: combined read and write
        cyc(BA, 1'b1, 1'b1, 32'hC0DE_C0DE, 1'b0, "R6 combined");
        cyc(BA, 1'b0, 1'b1, '0, 1'b0, "R6 single step");
        // R8: foreign addresses
        cyc(8'h2C, 1'b1, 1'b0, 32'hDEAD_DEAD, 1'b0, "R8 foreign wr");
        cyc(8'h00, 1'b0, 1'b1, '0, 1'b0, "R8 foreign rd");
        cyc(BA, 1'b0, 1'b1, '0, 1'b0, "R8 ptr unchanged");
        // R7: clear alone, then clear with access
        cyc(8'h00, 1'b0, 1'b0, '0, 1'b1, "R7 clear");
        cyc(BA, 1'b0, 1'b1, '0, 1'b0, "R7 after clear");
        cyc(BA, 1'b0, 1'b1, '0, 1'b0, "R7 step");
        cyc(BA, 1'b1, 1'b0, 32'h7777_0001, 1'b1, "R7 clear with write");
        cyc(BA, 1'b0, 1'b1, '0, 1'b0, "R7 entry 0 after clear");
        // R5 R8: pseudo-random mixed traffic
        for (int i = 0; i < 300; i++) begin
            int s;
            s = (i * 37 + 11) % 23;
            cyc((s % 5 == 0) ? 8'h24 : BA, (s % 3) == 0, (s % 2) == 1,
                32'(i) * 32'h0101_0107, (s == 7), "R5 traffic");
        end
        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < D; k++) m_bank[k] = '0;
        m_ptr = 0; m_rdata = '0;
        compare("R1 re-reset");
        cyc(BA, 1'b1, 1'b0, 32'h5555_AAAA, 1'b0, "R1 ptr at 0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule